// File: doc/BRIEF.md
# Operand Address Resolver for an 8-bit Processor

This block takes one instruction's addressing-mode code, its 16-bit operand field and the current index and accumulator values, and works out four results. These are the effective address, the operand byte, the instruction length in bytes, and the cycle count including any page-crossing penalty. It fetches bytes through a synchronous single-port read interface. That means two pointer bytes for the two pointer-based modes, then the operand byte itself for every memory mode.

A one-cycle `start` pulse hands a request to the block, and a one-cycle `done` pulse returns the result. `start` is accepted only while the block is idle. A `start` that arrives during a resolution is dropped, which is the only back-pressure rule, so the requester must wait for `done` before it issues again. All inputs are captured on the accepted `start`. The four result outputs change only on the edge that raises `done`, and they hold until the next completion.

Top module: `operand_resolver`

## Requirements
- R1: Mode codes: 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 absolute, 7 absolute+X, 8 absolute+Y, 9 absolute indirect, 10 pre-indexed indirect, 11 post-indexed indirect, 12 relative; codes 13 to 15 act like implied. Codes 3 to 5 give an address of 0x00 in the high byte and (operand low byte + index) mod 256 in the low byte. Codes 6 to 8 give operand, operand+X and operand+Y modulo 65536.
- R2: Mode 10 reads the pointer low byte at operand+X and the high byte at operand+X+1, and its address is high*256+low. Mode 11 reads the low byte at operand and the high byte at operand+1, and adds Y to the 16-bit pointer (mod 65536).
- R3: Modes 0, 1, 2, 9, 12 and 13 to 15 return an effective address of zero.
- R4: The operand byte is the operand's low byte in mode 2 and the accumulator in mode 1. Modes 3 to 8, 10 and 11 read it from memory at the effective address. All other modes return zero.
- R5: Length is 3 for modes 6 to 8 and 1 for modes 0, 1 and 13 to 15. It is 2 for every other mode.
- R6: Class codes: 0 read, 1 read-modify-write, 2 store, 3 other. Read: immediate 2, zero page 3, zero page+X/+Y and absolute variants 4, post-indexed 5, pre-indexed 6. Read-modify-write: accumulator 2, zero page 5, zero page+X and absolute 6, absolute+X 7. Store: zero page 3, zero page+X/+Y and absolute 4, absolute+X/+Y 5, both pointer modes 6. Class 3 returns the `fixed_cycles` input. Combinations not listed give 2.
- R7: For class 0 only, one cycle is added in modes 7, 8 and 11 when the high byte of the base differs from the high byte of the effective address. The base is the operand for modes 7 and 8 and the fetched pointer for mode 11.
- R8: `done` is high for exactly one cycle. It rises 2 cycles after the accepting edge for non-memory modes, 3 for modes 3 to 8, and 5 for modes 10 and 11.
- R9: `mem_rd` is asserted for 0, 1 and 3 cycles per resolution respectively, and never while `done` is high. Read data is taken one cycle after its address.
- R10: A `start` during a resolution is ignored. Results and inputs captured at acceptance are unaffected, and no extra `done` follows. Results hold after `done`.
- R11: After reset, `done`, `mem_rd`, `eff_addr`, `op_value`, `inst_len` and `cycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 4 | Addressing-mode code |
| iclass | input | 2 | Instruction class code |
| operand | input | 16 | Instruction operand field |
| x_reg | input | 8 | X index value |
| y_reg | input | 8 | Y index value |
| acc_reg | input | 8 | Accumulator value |
| fixed_cycles | input | 4 | Cycle count for class 3 |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, one cycle after address |
| done | output | 1 | Result-valid pulse |
| eff_addr | output | 16 | Effective address |
| op_value | output | 8 | Operand byte |
| inst_len | output | 2 | Instruction length in bytes |
| cycles | output | 4 | Cycle count with penalty |

## Verification
A wrong pointer byte or a misrouted index shows up in `eff_addr` and `op_value` on the very `done` pulse of the affected resolution, because the bench memory returns a distinct function of every address. A sequencer that skips or repeats a state shows up as a `done` one or more cycles early or late, or as a wrong number of `mem_rd` cycles. Both are counted per request. A latch that reloads while busy changes the results or adds a second `done` within a few cycles of the dropped `start`.

// File: rtl/opres_pkg.sv
package opres_pkg;
  localparam int MODE_W = 4;
  localparam int CLS_W  = 2;

  localparam logic [MODE_W-1:0] M_IMPL = 4'd0;
  localparam logic [MODE_W-1:0] M_ACC  = 4'd1;
  localparam logic [MODE_W-1:0] M_IMM  = 4'd2;
  localparam logic [MODE_W-1:0] M_ZP   = 4'd3;
  localparam logic [MODE_W-1:0] M_ZPX  = 4'd4;
  localparam logic [MODE_W-1:0] M_ZPY  = 4'd5;
  localparam logic [MODE_W-1:0] M_ABS  = 4'd6;
  localparam logic [MODE_W-1:0] M_ABSX = 4'd7;
  localparam logic [MODE_W-1:0] M_ABSY = 4'd8;
  localparam logic [MODE_W-1:0] M_IND  = 4'd9;
  localparam logic [MODE_W-1:0] M_PRE  = 4'd10;
  localparam logic [MODE_W-1:0] M_POST = 4'd11;
  localparam logic [MODE_W-1:0] M_REL  = 4'd12;

  localparam logic [CLS_W-1:0] C_READ  = 2'd0;
  localparam logic [CLS_W-1:0] C_RMW   = 2'd1;
  localparam logic [CLS_W-1:0] C_STORE = 2'd2;
  localparam logic [CLS_W-1:0] C_OTHER = 2'd3;

  function automatic logic uses_ptr(input logic [MODE_W-1:0] m);
    return (m == M_PRE) || (m == M_POST);
  endfunction

  function automatic logic reads_mem(input logic [MODE_W-1:0] m);
    return (m >= M_ZP && m <= M_ABSY) || uses_ptr(m);
  endfunction
endpackage

// File: rtl/opres_ea.sv
module opres_ea
  import opres_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [DATA_W-1:0] xv,
  input  logic [DATA_W-1:0] yv,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] ptr_base,
  output logic [ADDR_W-1:0] pen_base
);
  localparam int PAD = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] xw, yw, sum_x, sum_y;
  logic [DATA_W-1:0] zp_x, zp_y;

  always_comb begin
    xw    = {{PAD{1'b0}}, xv};
    yw    = {{PAD{1'b0}}, yv};
    sum_x = opnd + xw;
    sum_y = opnd + yw;
    zp_x  = sum_x[DATA_W-1:0];
    zp_y  = sum_y[DATA_W-1:0];
  end

  always_comb begin
    unique case (mode)
      M_ZP:    ea = {{PAD{1'b0}}, opnd[DATA_W-1:0]};
      M_ZPX:   ea = {{PAD{1'b0}}, zp_x};
      M_ZPY:   ea = {{PAD{1'b0}}, zp_y};
      M_ABS:   ea = opnd;
      M_ABSX:  ea = sum_x;
      M_ABSY:  ea = sum_y;
      M_PRE:   ea = ptr;
      M_POST:  ea = ptr + yw;
      default: ea = '0;
    endcase
  end

  always_comb begin
    ptr_base = (mode == M_PRE) ? sum_x : opnd;
    pen_base = (mode == M_POST) ? ptr : opnd;
  end
endmodule

// File: rtl/opres_timing.sv
module opres_timing
  import opres_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CYC_W  = 4
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [CLS_W-1:0]  cls,
  input  logic [CYC_W-1:0]  fixed,
  input  logic [ADDR_W-1:0] pen_base,
  input  logic [ADDR_W-1:0] ea,
  output logic [1:0]        len,
  output logic [CYC_W-1:0]  cyc
);
  logic [CYC_W-1:0] base;
  logic             crossed;
  logic             pen_mode;

  always_comb begin
    unique case (mode)
      M_ABS, M_ABSX, M_ABSY:      len = 2'd3;
      M_IMPL, M_ACC, 4'd13, 4'd14, 4'd15: len = 2'd1;
      default:                    len = 2'd2;
    endcase
  end

  always_comb begin
    base = CYC_W'(2);
    unique case (cls)
      C_READ: begin
        unique case (mode)
          M_IMM:                         base = CYC_W'(2);
          M_ZP:                          base = CYC_W'(3);
          M_ZPX, M_ZPY, M_ABS, M_ABSX, M_ABSY: base = CYC_W'(4);
          M_POST:                        base = CYC_W'(5);
          M_PRE:                         base = CYC_W'(6);
          default:                       base = CYC_W'(2);
        endcase
      end
      C_RMW: begin
        unique case (mode)
          M_ACC:        base = CYC_W'(2);
          M_ZP:         base = CYC_W'(5);
          M_ZPX, M_ABS: base = CYC_W'(6);
          M_ABSX:       base = CYC_W'(7);
          default:      base = CYC_W'(2);
        endcase
      end
      C_STORE: begin
        unique case (mode)
          M_ZP:                base = CYC_W'(3);
          M_ZPX, M_ZPY, M_ABS: base = CYC_W'(4);
          M_ABSX, M_ABSY:      base = CYC_W'(5);
          M_PRE, M_POST:       base = CYC_W'(6);
          default:             base = CYC_W'(2);
        endcase
      end
      default: base = fixed;
    endcase
  end

  always_comb begin
    pen_mode = (cls == C_READ) &&
               ((mode == M_ABSX) || (mode == M_ABSY) || (mode == M_POST));
    crossed  = pen_base[ADDR_W-1:DATA_W] != ea[ADDR_W-1:DATA_W];
    cyc      = base + CYC_W'(pen_mode && crossed);
  end
endmodule

// File: rtl/opres_seq.sv
module opres_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic go_ptr,
  input  logic go_mem,
  output logic accept,
  output logic st_plo,
  output logic st_phi,
  output logic st_data,
  output logic st_fin
);
  typedef enum logic [2:0] {S_IDLE, S_PLO, S_PHI, S_DATA, S_FIN} state_e;
  state_e st, st_nx;

  always_comb begin
    accept = (st == S_IDLE) && start;
    st_nx  = st;
    unique case (st)
      S_IDLE: if (start) st_nx = go_ptr ? S_PLO : (go_mem ? S_DATA : S_FIN);
      S_PLO:  st_nx = S_PHI;
      S_PHI:  st_nx = S_DATA;
      S_DATA: st_nx = S_FIN;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  assign st_plo  = (st == S_PLO);
  assign st_phi  = (st == S_PHI);
  assign st_data = (st == S_DATA);
  assign st_fin  = (st == S_FIN);
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
  import opres_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CYC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [1:0]        iclass,
  input  logic [ADDR_W-1:0] operand,
  input  logic [DATA_W-1:0] x_reg,
  input  logic [DATA_W-1:0] y_reg,
  input  logic [DATA_W-1:0] acc_reg,
  input  logic [CYC_W-1:0]  fixed_cycles,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [DATA_W-1:0] op_value,
  output logic [1:0]        inst_len,
  output logic [CYC_W-1:0]  cycles
);
  logic [MODE_W-1:0] mode_q;
  logic [CLS_W-1:0]  cls_q;
  logic [ADDR_W-1:0] opnd_q;
  logic [DATA_W-1:0] x_q, y_q, acc_q;
  logic [CYC_W-1:0]  fixed_q;
  logic [DATA_W-1:0] ptr_lo_q, ptr_hi_q;

  logic accept, st_plo, st_phi, st_data, st_fin;
  logic [ADDR_W-1:0] ptr_live, ea, ptr_base, pen_base;
  logic [1:0]        len_w;
  logic [CYC_W-1:0]  cyc_w;
  logic [DATA_W-1:0] val_w;

  opres_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .go_ptr(uses_ptr(mode)), .go_mem(reads_mem(mode)),
    .accept(accept), .st_plo(st_plo), .st_phi(st_phi),
    .st_data(st_data), .st_fin(st_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      cls_q   <= '0;
      opnd_q  <= '0;
      x_q     <= '0;
      y_q     <= '0;
      acc_q   <= '0;
      fixed_q <= '0;
    end else if (accept) begin
      mode_q  <= mode;
      cls_q   <= iclass;
      opnd_q  <= operand;
      x_q     <= x_reg;
      y_q     <= y_reg;
      acc_q   <= acc_reg;
      fixed_q <= fixed_cycles;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_lo_q <= '0;
      ptr_hi_q <= '0;
    end else begin
      if (st_phi) ptr_lo_q <= mem_rdata;
      if (st_data && uses_ptr(mode_q)) ptr_hi_q <= mem_rdata;
    end
  end

  // High pointer byte arrives on the read port in the same cycle the data address is needed
  assign ptr_live = {(st_data ? mem_rdata : ptr_hi_q), ptr_lo_q};

  opres_ea #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ea (
    .mode(mode_q), .opnd(opnd_q), .xv(x_q), .yv(y_q), .ptr(ptr_live),
    .ea(ea), .ptr_base(ptr_base), .pen_base(pen_base)
  );

  opres_timing #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(CYC_W)) u_tim (
    .mode(mode_q), .cls(cls_q), .fixed(fixed_q), .pen_base(pen_base), .ea(ea),
    .len(len_w), .cyc(cyc_w)
  );

  always_comb begin
    mem_rd = st_plo | st_phi | st_data;
    if (st_plo)      mem_addr = ptr_base;
    else if (st_phi) mem_addr = ptr_base + ADDR_W'(1);
    else             mem_addr = ea;
  end

  always_comb begin
    if (reads_mem(mode_q))   val_w = mem_rdata;
    else if (mode_q == M_IMM) val_w = opnd_q[DATA_W-1:0];
    else if (mode_q == M_ACC) val_w = acc_q;
    else                      val_w = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      eff_addr <= '0;
      op_value <= '0;
      inst_len <= '0;
      cycles   <= '0;
    end else begin
      done <= st_fin;
      if (st_fin) begin
        eff_addr <= ea;
        op_value <= val_w;
        inst_len <= len_w;
        cycles   <= cyc_w;
      end
    end
  end
endmodule

// File: rtl/opres_chk.sv
module opres_chk
  import opres_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [DATA_W-1:0] op_value,
  input logic [1:0]        inst_len,
  input logic [MODE_W-1:0] mode_q
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_rd_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !done);

  p_rd_then_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !done);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(eff_addr) || !$stable(op_value)) |-> done);

  p_len_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inst_len != 2'd0));

  p_zero_ea_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reads_mem(mode_q)) |-> (eff_addr == '0));
endmodule

bind operand_resolver opres_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_rd(mem_rd),
  .eff_addr(eff_addr), .op_value(op_value), .inst_len(inst_len), .mode_q(mode_q)
);

// File: tb/tb_operand_resolver.sv
`timescale 1ns/1ps
module tb_operand_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  iclass = '0;
  logic [15:0] operand = '0;
  logic [7:0]  x_reg = '0, y_reg = '0, acc_reg = '0;
  logic [3:0]  fixed_cycles = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [15:0] eff_addr;
  logic [7:0]  op_value;
  logic [1:0]  inst_len;
  logic [3:0]  cycles;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  operand_resolver dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .iclass(iclass),
    .operand(operand), .x_reg(x_reg), .y_reg(y_reg), .acc_reg(acc_reg),
    .fixed_cycles(fixed_cycles), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .eff_addr(eff_addr),
    .op_value(op_value), .inst_len(inst_len), .cycles(cycles)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected-value model
  logic [15:0] e_ea, e_ptr;
  logic [7:0]  e_val;
  int          e_len, e_cyc, e_lat, e_rds;
  bit          e_pen;

  task automatic model(input logic [3:0] m, input logic [1:0] c, input logic [15:0] op,
                       input logic [7:0] x, input logic [7:0] y, input logic [7:0] a,
                       input logic [3:0] fx);
    logic [15:0] b;
    bit memm, ptrm;
    e_ptr = '0;
    case (m)
      4'd3:  e_ea = {8'h00, op[7:0]};
      4'd4:  e_ea = {8'h00, op[7:0] + x};
      4'd5:  e_ea = {8'h00, op[7:0] + y};
      4'd6:  e_ea = op;
      4'd7:  e_ea = op + {8'h00, x};
      4'd8:  e_ea = op + {8'h00, y};
      4'd10: begin b = op + {8'h00, x}; e_ptr = {memf(b + 16'd1), memf(b)}; e_ea = e_ptr; end
      4'd11: begin e_ptr = {memf(op + 16'd1), memf(op)}; e_ea = e_ptr + {8'h00, y}; end
      default: e_ea = '0;
    endcase
    ptrm = (m == 4'd10) || (m == 4'd11);
    memm = (m >= 4'd3 && m <= 4'd8) || ptrm;
    if (memm)           e_val = memf(e_ea);
    else if (m == 4'd2) e_val = op[7:0];
    else if (m == 4'd1) e_val = a;
    else                e_val = '0;
    if (m >= 4'd6 && m <= 4'd8) e_len = 3;
    else if (m <= 4'd1 || m >= 4'd13) e_len = 1;
    else e_len = 2;
    e_cyc = 2;
    case (c)
      2'd0: case (m)
              4'd3: e_cyc = 3;
              4'd4, 4'd5, 4'd6, 4'd7, 4'd8: e_cyc = 4;
              4'd11: e_cyc = 5;
              4'd10: e_cyc = 6;
              default: e_cyc = 2;
            endcase
      2'd1: case (m)
              4'd3: e_cyc = 5;
              4'd4, 4'd6: e_cyc = 6;
              4'd7: e_cyc = 7;
              default: e_cyc = 2;
            endcase
      2'd2: case (m)
              4'd3: e_cyc = 3;
              4'd4, 4'd5, 4'd6: e_cyc = 4;
              4'd7, 4'd8: e_cyc = 5;
              4'd10, 4'd11: e_cyc = 6;
              default: e_cyc = 2;
            endcase
      default: e_cyc = int'(fx);
    endcase
    e_pen = 1'b0;
    if (c == 2'd0) begin
      if ((m == 4'd7 || m == 4'd8) && (op[15:8] != e_ea[15:8])) e_pen = 1'b1;
      if (m == 4'd11 && (e_ptr[15:8] != e_ea[15:8])) e_pen = 1'b1;
    end
    if (e_pen) e_cyc = e_cyc + 1;
    e_lat = ptrm ? 5 : (memm ? 3 : 2);
    e_rds = ptrm ? 3 : (memm ? 1 : 0);
  endtask

  task automatic run_one(input logic [3:0] m, input logic [1:0] c, input logic [15:0] op,
                         input logic [7:0] x, input logic [7:0] y, input logic [7:0] a,
                         input logic [3:0] fx);
    int n, rds;
    bit seen;
    model(m, c, op, x, y, a, fx);
    @(negedge clk);
    mode = m; iclass = c; operand = op; x_reg = x; y_reg = y; acc_reg = a;
    fixed_cycles = fx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1; rds = 0; seen = 1'b0;
    while (n <= 20) begin
      if (mem_rd) rds++;
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
      n++;
    end
    chk(seen && n == e_lat, "R8", "latency", n, e_lat);
    chk(rds == e_rds, "R9", "read count", rds, e_rds);
    if (m >= 4'd3 && m <= 4'd8)   chk(eff_addr == e_ea, "R1", "direct ea", eff_addr, e_ea);
    else if (m == 4'd10 || m == 4'd11) chk(eff_addr == e_ea, "R2", "pointer ea", eff_addr, e_ea);
    else                           chk(eff_addr == e_ea, "R3", "zero ea", eff_addr, e_ea);
    chk(op_value == e_val, "R4", "value", op_value, e_val);
    chk(int'(inst_len) == e_len, "R5", "length", inst_len, e_len);
    if (e_pen) chk(int'(cycles) == e_cyc, "R7", "cycles with penalty", cycles, e_cyc);
    else       chk(int'(cycles) == e_cyc, "R6", "base cycles", cycles, e_cyc);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
  endtask

  logic [15:0] pat_op [4] = '{16'h1234, 16'h12F0, 16'h00FF, 16'hFFFF};
  logic [7:0]  pat_x  [4] = '{8'h10, 8'h20, 8'hFF, 8'h01};
  logic [7:0]  pat_y  [4] = '{8'h20, 8'h05, 8'h01, 8'hFF};

  initial begin
    #500000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(done == 0 && mem_rd == 0, "R11", "reset strobes", {done, mem_rd}, 0);
    chk(eff_addr == 0 && op_value == 0, "R11", "reset results", eff_addr, 0);
    chk(inst_len == 0 && cycles == 0, "R11", "reset len/cyc", cycles, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 4; c++)
        for (int m = 0; m < 16; m++)
          run_one(4'(m), 2'(c), pat_op[p], pat_x[p], pat_y[p], 8'hA5 ^ 8'(p),
                  4'(3 + p * 2));

    // R10: a start during a busy pointer resolution is dropped
    begin
      int n;
      bit seen;
      logic [15:0] ea0;
      logic [7:0]  v0;
      model(4'd11, 2'd0, 16'h40FE, 8'h00, 8'hF0, 8'h11, 4'd0);
      @(negedge clk);
      mode = 4'd11; iclass = 2'd0; operand = 16'h40FE; x_reg = 8'h00;
      y_reg = 8'hF0; acc_reg = 8'h11; start = 1'b1;
      @(negedge clk);
      mode = 4'd2; operand = 16'h0077; y_reg = 8'h00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 2; seen = 1'b0;
      while (n <= 20) begin
        if (done) begin seen = 1'b1; break; end
        @(negedge clk);
        n++;
      end
      chk(seen && n == 5, "R10", "busy start latency", n, 5);
      chk(eff_addr == e_ea, "R10", "busy start ea", eff_addr, e_ea);
      chk(op_value == e_val, "R10", "busy start value", op_value, e_val);
      ea0 = eff_addr; v0 = op_value;
      seen = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done) seen = 1'b1;
      end
      chk(!seen, "R10", "no second done", seen, 0);
      chk(eff_addr == ea0 && op_value == v0, "R10", "results held", eff_addr, ea0);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule